// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides its clock by a programmable ratio N = P·B + A. It emits a one-cycle pulse once per N input cycles, which suits the feedback input of a phase detector. A dual-modulus prescaler divides by P+1 while a swallow count is still pending. After that count runs out, the prescaler divides by P until the main count finishes. At that point the period ends and every counter reloads. A select input chooses the lower modulus P. With the default base of 16, P is 16 when the select is low and 32 when it is high. A base of 8 gives the 8/9 and 16/17 variant.

A new setting is sampled only at a reload. Reloads happen at the end of each period and in every cycle in which the divider is held. A period that is already running is therefore never shortened or stretched by a write. A setting that breaks the rules is refused at its sampling point: the previous setting stays active and an error flag rises. The rules are: the main count is at least 3, the swallow count is no larger than the main count, and the swallow count is no larger than P. While the run input is low, the divider sits at its load point. When run returns high, counting starts from a clean period.

Top module: `pulse_swallow_div`

## Requirements
- R1: With `wide_sel` = 0 the lower modulus P is 16, and with `wide_sel` = 1 it is 32. Each output period lasts exactly P·`main_val` + `swallow_val` input cycles.
- R2: `div_pulse` is high for exactly one cycle per period. Consecutive pulses are spaced by the period length of R1.
- R3: Settings are sampled only at the clock edge that ends a period. That edge is the same edge on which `div_pulse` goes high. A change made part-way through a period does not alter that period. The last value present at its end governs the next period.
- R4: While `run` is low, `div_pulse` stays low and the counters are held at their load point. When `run` rises, the first pulse appears after exactly N input cycles, where N comes from the settings sampled at the last held cycle.
- R5: A setting with `main_val` below 3 is refused. The previously active setting keeps governing the periods, and `cfg_err` goes high.
- R6: A setting with `swallow_val` greater than `main_val` is refused in the same way. A setting with `swallow_val` equal to `main_val` is legal.
- R7: A setting with `swallow_val` greater than P is refused in the same way. A setting with `swallow_val` equal to P is legal.
- R8: `cfg_err` is updated at every sampling point. It is high when the sampled setting was refused and low when it was accepted, so a legal setting clears it.
- R9: After reset, `div_pulse` and `cfg_err` are low. The active setting is P = 16, swallow 0, main 3, which gives a period of 48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to count; low holds the counters at the load point |
| wide_sel | input | 1 | Modulus pair select: 0 gives P = 16, 1 gives P = 32 (default base) |
| swallow_val | input | 5 | Swallow count A |
| main_val | input | 13 | Main count B |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |
| cfg_err | output | 1 | High when the last sampled setting was refused |

## Verification
Two events can fall on the same edge: the end of a period and the acceptance or refusal of a new setting. The edge that raises the pulse also samples the inputs and updates `cfg_err`. The bench provokes this by writing a setting right after each pulse, including refused settings, and then rewriting it halfway through a period. A scoreboard queue predicts which setting governs each period. The period length and `cfg_err` are both judged at the pulse that closes the period in which the write was made. A hold in the middle of a period is also checked: the first period after release must be a full, fresh one.

// File: rtl/psd_pkg.sv
package psd_pkg;

    parameter int SWALLOW_W = 5;
    parameter int MAIN_W    = 13;

    typedef struct packed {
        logic                 wide;
        logic [SWALLOW_W-1:0] swallow;
        logic [MAIN_W-1:0]    main;
    } div_cfg_t;

    function automatic int low_modulus(input logic wide, input int base);
        return wide ? 2 * base : base;
    endfunction

    function automatic logic cfg_ok(input div_cfg_t c, input int base, input int min_main);
        int sw;
        int mn;
        sw = int'(c.swallow);
        mn = int'(c.main);
        return (mn >= min_main) && (sw <= mn) && (sw <= low_modulus(c.wide, base));
    endfunction

endpackage

// File: rtl/psd_cfg.sv
module psd_cfg
    import psd_pkg::*;
#(
    parameter int BASE_MOD = 16,
    parameter int MIN_MAIN = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  div_cfg_t req,
    output div_cfg_t active,
    output div_cfg_t upcoming,
    output logic     err
);

    localparam div_cfg_t RST_CFG = '{wide: 1'b0, swallow: '0, main: MAIN_W'(MIN_MAIN)};

    logic req_ok;

    always_comb begin
        req_ok   = cfg_ok(req, BASE_MOD, MIN_MAIN);
        upcoming = req_ok ? req : active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= RST_CFG;
            err    <= 1'b0;
        end else if (load) begin
            active <= upcoming;
            err    <= !req_ok;
        end
    end

    AST_ACTIVE_MAIN_MIN: assert property (@(posedge clk) disable iff (rst)
        int'(active.main) >= MIN_MAIN); // R5
    AST_ACTIVE_SW_LE_MAIN: assert property (@(posedge clk) disable iff (rst)
        int'(active.swallow) <= int'(active.main)); // R6
    AST_ACTIVE_SW_LE_P: assert property (@(posedge clk) disable iff (rst)
        int'(active.swallow) <= low_modulus(active.wide, BASE_MOD)); // R7
    AST_CFG_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> $stable(active)); // R3
    AST_ERR_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(load)); // R8

endmodule

// File: rtl/psd_core.sv
module psd_core
    import psd_pkg::*;
#(
    parameter int BASE_MOD = 16,
    parameter int MIN_MAIN = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  div_cfg_t active,
    input  div_cfg_t upcoming,
    output logic     load,
    output logic     div_pulse
);

    localparam int PRE_W = $clog2(2 * BASE_MOD + 1);

    logic [PRE_W-1:0]     pre_cnt;
    logic [SWALLOW_W-1:0] sw_left;
    logic [SWALLOW_W-1:0] sw_next;
    logic [MAIN_W-1:0]    main_left;
    logic                 period_end;
    logic                 pulse_q;

    // Start value of the prescaler count: P+1 cycles while swallowing, else P.
    function automatic logic [PRE_W-1:0] start_count(input logic wide, input logic swallowing);
        return PRE_W'(low_modulus(wide, BASE_MOD) - (swallowing ? 0 : 1));
    endfunction

    always_comb begin
        period_end = (pre_cnt == '0) && (main_left == MAIN_W'(1));
        load       = !run || period_end;
        sw_next    = (sw_left == '0) ? '0 : sw_left - SWALLOW_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt   <= PRE_W'(BASE_MOD - 1);
            sw_left   <= '0;
            main_left <= MAIN_W'(MIN_MAIN);
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= run && period_end;
            if (load) begin
                main_left <= upcoming.main;
                sw_left   <= upcoming.swallow;
                pre_cnt   <= start_count(upcoming.wide, upcoming.swallow != '0);
            end else if (pre_cnt == '0) begin
                main_left <= main_left - MAIN_W'(1);
                sw_left   <= sw_next;
                pre_cnt   <= start_count(active.wide, sw_next != '0);
            end else begin
                pre_cnt <= pre_cnt - PRE_W'(1);
            end
        end
    end

    assign div_pulse = pulse_q;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse); // R2
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run |=> !div_pulse); // R4
    AST_SWALLOW_LE_MAIN: assert property (@(posedge clk) disable iff (rst)
        int'(sw_left) <= int'(main_left)); // R6
    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(pre_cnt) <= 2 * BASE_MOD); // R1

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int BASE_MOD = 16,
    parameter int MIN_MAIN = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 wide_sel,
    input  logic [SWALLOW_W-1:0] swallow_val,
    input  logic [MAIN_W-1:0]    main_val,
    output logic                 div_pulse,
    output logic                 cfg_err
);

    div_cfg_t req;
    div_cfg_t active;
    div_cfg_t upcoming;
    logic     load;

    always_comb begin
        req.wide    = wide_sel;
        req.swallow = swallow_val;
        req.main    = main_val;
    end

    psd_cfg #(
        .BASE_MOD (BASE_MOD),
        .MIN_MAIN (MIN_MAIN)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .req      (req),
        .active   (active),
        .upcoming (upcoming),
        .err      (cfg_err)
    );

    psd_core #(
        .BASE_MOD (BASE_MOD),
        .MIN_MAIN (MIN_MAIN)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .active    (active),
        .upcoming  (upcoming),
        .load      (load),
        .div_pulse (div_pulse)
    );

endmodule

// File: tb/pulse_swallow_div_tb.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        wide_sel = 1'b0;
    logic [4:0]  swallow_val = '0;
    logic [12:0] main_val = '0;
    logic        div_pulse;
    logic        cfg_err;

    int n_cmp = 0;
    int n_bad = 0;
    int expq[$];
    bit mon_en = 1'b0;
    int cyc_cnt = 0;
    int hold_pulses = 0;
    int cur_n = 48;
    int exp_n;

    always #2.5 clk = ~clk;

    pulse_swallow_div u_dut (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .wide_sel    (wide_sel),
        .swallow_val (swallow_val),
        .main_val    (main_val),
        .div_pulse   (div_pulse),
        .cfg_err     (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nval(input bit hi, input int a, input int b);
        return (hi ? 32 : 16) * b + a;
    endfunction

    function automatic bit legal(input bit hi, input int a, input int b);
        return (b >= 3) && (a <= b) && (a <= (hi ? 32 : 16));
    endfunction

    // Monitor: counts input cycles and pops the expected period at each pulse.
    always @(negedge clk) begin
        if (mon_en) begin
            cyc_cnt++;
            if (div_pulse) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R2 unexpected pulse", cyc_cnt, 0);
                end else begin
                    exp_n = expq.pop_front();
                    check(cyc_cnt == exp_n, "R1 period", cyc_cnt, exp_n);
                end
                cyc_cnt = 0;
            end
        end else if (div_pulse) begin
            hold_pulses++;
        end
    end

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
        #1;
    endtask

    task automatic drive(input bit hi, input int a, input int b);
        wide_sel    = hi;
        swallow_val = 5'(a);
        main_val    = 13'(b);
    endtask

    // Driver: applies a setting, predicts the next period, judges cfg_err at the boundary.
    task automatic apply(input bit hi, input int a, input int b, input string req);
        bit ok;
        ok = legal(hi, a, b);
        drive(hi, a, b);
        if (ok) cur_n = nval(hi, a, b);
        expq.push_back(cur_n);
        wait_pulse();
        check(cfg_err == !ok, req, int'(cfg_err), int'(!ok));
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state
        drive(1'b0, 0, 0);
        repeat (4) @(negedge clk);
        #1;
        check(div_pulse == 1'b0, "R9 pulse in reset", int'(div_pulse), 0);
        check(cfg_err == 1'b0, "R9 err in reset", int'(cfg_err), 0);
        rst = 1'b0;

        // R4 held, R5 main 0 refused while held
        repeat (10) @(negedge clk);
        #1;
        check(cfg_err == 1'b1, "R5 main below 3 refused", int'(cfg_err), 1);
        check(hold_pulses == 0, "R4 no pulse while held", hold_pulses, 0);

        // R9: refused setting keeps the reset default, period 48
        @(negedge clk);
        #1;
        run     = 1'b1;
        cyc_cnt = 0;
        mon_en  = 1'b1;
        expq.push_back(48);

        apply(1'b0, 5, 20, "R8 err cleared");
        apply(1'b1, 0, 3, "R1 wide select");
        apply(1'b0, 16, 16, "R7 swallow equal P legal");
        apply(1'b0, 17, 20, "R7 swallow above P refused");
        apply(1'b1, 31, 31, "R6 swallow equal main legal");
        apply(1'b0, 10, 8, "R6 swallow above main refused");
        apply(1'b1, 0, 2, "R5 main 2 refused");
        apply(1'b0, 3, 3, "R8 legal after refusal");

        for (int i = 0; i < 20; i++) begin
            bit hi;
            int b;
            int amax;
            hi   = 1'($urandom_range(0, 1));
            b    = int'($urandom_range(3, 120));
            amax = (b < (hi ? 32 : 16)) ? b : (hi ? 32 : 16);
            if (amax > 31) amax = 31;
            apply(hi, int'($urandom_range(0, amax)), b, "R1 random");
        end

        // R3: a first write is overwritten mid-period; only the last one counts
        drive(1'b1, 7, 9);
        repeat (10) @(negedge clk);
        #1;
        drive(1'b0, 4, 11);
        cur_n = nval(1'b0, 4, 11);
        expq.push_back(cur_n);
        wait_pulse();
        check(cfg_err == 1'b0, "R3 mid-period write", int'(cfg_err), 0);
        expq.push_back(cur_n);
        wait_pulse();

        // R4: hold in mid-period, change setting, release gives a full fresh period
        repeat (30) @(negedge clk);
        #1;
        run    = 1'b0;
        mon_en = 1'b0;
        expq.delete();
        hold_pulses = 0;
        drive(1'b0, 2, 10);
        repeat (20) @(negedge clk);
        #1;
        check(hold_pulses == 0, "R4 no pulse while held", hold_pulses, 0);
        run     = 1'b1;
        cyc_cnt = 0;
        mon_en  = 1'b1;
        expq.push_back(nval(1'b0, 2, 10));
        wait_pulse();
        check(expq.size() == 0, "R4 first period after release", expq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule